// File: doc/BRIEF.md
# Serial Engine Interrupt Aggregator

This block gathers the event sources of a serial-peripheral engine and turns them into a single interrupt line. Each source has a status bit, an enable bit and a write-one-to-clear bit. The status bits set whether or not they are enabled. The interrupt line is high while any status bit is set together with its enable.

Most sources are pulse events. Command completion, cancel completion, abort completion, the final-word-received event and seven error conditions are each captured on a rising input edge and held until software clears them. Two sources are level-latched: the transmit and receive watermark comparators. Each compares a FIFO fill level against a programmable threshold. Clearing one of them while its condition still holds drops it for exactly one cycle, and it then sets again. A third comparator drives a ready-for-request output from the receive fill level. The FIFOs and the serial engine sit outside this block; their fill levels and event pulses arrive as inputs.

Status bit map, used by the event, clear and enable words: 0 command done, 1 cancel done, 2 abort done, 3 receive last word, 4 command overrun, 5 illegal command, 6 command failure, 7 transmit FIFO read error, 8 transmit FIFO write error, 9 receive FIFO read error, 10 receive FIFO write error, 11 transmit watermark, 12 receive watermark.

Top module: `sei_irq_top`

## Requirements
- R1: After reset the status word and the enable word are zero and irq_o is low.
- R2: An edge-captured status bit (bits 0 to 10) sets on the first clock edge at which its evt_i bit is high after having been low. An input that stays high sets the bit only once, so once that bit is cleared it stays clear while the input remains high.
- R3: An edge-captured status bit stays set until a clear write carries a 1 in its position. Clear writes with a 0 in that position leave it unchanged.
- R4: When an edge-captured bit's rising event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R5: Status bit 11 sets when tx_thr_i is nonzero and tx_fill_i is less than or equal to tx_thr_i. A threshold of 0 never sets it.
- R6: Status bit 12 sets when rx_thr_i is nonzero and rx_fill_i is greater than or equal to rx_thr_i. A threshold of 0 never sets it.
- R7: Bits 11 and 12 are latched: they stay set after their condition goes away. A clear write takes priority over the condition in the same cycle, so the bit reads 0 for one cycle and then sets again if the condition still holds.
- R8: Status bits set whatever their enable bit is. irq_o is the OR of status AND enable, and it follows the registers with no added cycle. An enable write takes effect at the next clock edge.
- R9: rx_rfr_o is high exactly when rx_fill_i is less than rfr_thr_i.
- R10: The seven error inputs (evt_i bits 4 to 10) are captured in separate status bits, independently of one another and of the other events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 11 | Event inputs, one per edge-captured status bit 0 to 10 |
| tx_fill_i | input | LVL_W | Transmit FIFO fill level |
| rx_fill_i | input | LVL_W | Receive FIFO fill level |
| tx_thr_i | input | LVL_W | Transmit watermark threshold, 0 disables |
| rx_thr_i | input | LVL_W | Receive watermark threshold, 0 disables |
| rfr_thr_i | input | LVL_W | Ready-for-request level for the receive side |
| en_we_i | input | 1 | Enable word write strobe |
| en_wdata_i | input | 13 | Enable word write data |
| clr_we_i | input | 1 | Clear write strobe |
| clr_wdata_i | input | 13 | Clear mask, 1 clears |
| status_o | output | 13 | Status word |
| irq_o | output | 1 | Interrupt request |
| rx_rfr_o | output | 1 | Receive side ready for more data |

## Verification
A wrong edge-detector register shows up on status_o one cycle after the input rises. It appears as a missing set, or as a held input that sets its bit again after a clear. A wrong status or enable register reaches status_o and irq_o right after the clock edge that follows the bad write or event, because neither path adds a cycle. A comparator with the wrong sense or the wrong zero handling shows up on bits 11 and 12, or on rx_rfr_o, in the same or the next cycle. The latched-level behaviour is exposed by the one-cycle dip after a clear.

// File: rtl/sei_irq_pkg.sv
package sei_irq_pkg;
  localparam int unsigned NUM_EDGE = 11;
  localparam int unsigned NUM_SRC  = NUM_EDGE + 2;
  localparam int unsigned BIT_TXWM = NUM_EDGE;
  localparam int unsigned BIT_RXWM = NUM_EDGE + 1;
  typedef logic [NUM_SRC-1:0]  src_vec_t;
  typedef logic [NUM_EDGE-1:0] evt_vec_t;
endpackage

// File: rtl/sei_edge_cap.sv
module sei_edge_cap #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= evt_i;
  end

  always_comb rise_o = evt_i & ~evt_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R2: one edge gives a single set pulse
    a_r2_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[i] |=> !rise_o[i]);
  end
endmodule

// File: rtl/sei_wm_cmp.sv
module sei_wm_cmp #(
  parameter int unsigned LVL_W = 5
) (
  input  logic [LVL_W-1:0] tx_fill_i,
  input  logic [LVL_W-1:0] rx_fill_i,
  input  logic [LVL_W-1:0] tx_thr_i,
  input  logic [LVL_W-1:0] rx_thr_i,
  input  logic [LVL_W-1:0] rfr_thr_i,
  output logic             tx_hit_o,
  output logic             rx_hit_o,
  output logic             rfr_o
);
  logic tx_on, rx_on;

  always_comb begin
    tx_on    = (tx_thr_i != '0);
    rx_on    = (rx_thr_i != '0);
    tx_hit_o = tx_on && (tx_fill_i <= tx_thr_i);
    rx_hit_o = rx_on && (rx_fill_i >= rx_thr_i);
    rfr_o    = (rx_fill_i < rfr_thr_i);
  end
endmodule

// File: rtl/sei_stat_bit.sv
module sei_stat_bit #(
  parameter bit LEVEL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic sts_o
);
  logic sts_q, sts_d, upd;

  always_comb begin
    upd = set_i | clr_i;
    if (LEVEL) sts_d = clr_i ? 1'b0 : (sts_q | set_i);
    else       sts_d = set_i | (sts_q & ~clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  sts_q <= 1'b0;
    else if (upd) sts_q <= sts_d;
  end

  assign sts_o = sts_q;

  // R3 / R7: a set bit only leaves through a clear
  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q && !clr_i) |=> sts_q);

  if (LEVEL) begin : g_lvl
    a_r7_clear_dips: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> !sts_q);
  end else begin : g_edge
    a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i |=> sts_q);
  end
endmodule

// File: rtl/sei_irq_top.sv
module sei_irq_top
  import sei_irq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  localparam int unsigned LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_EDGE-1:0] evt_i,
  input  logic [LVL_W-1:0]    tx_fill_i,
  input  logic [LVL_W-1:0]    rx_fill_i,
  input  logic [LVL_W-1:0]    tx_thr_i,
  input  logic [LVL_W-1:0]    rx_thr_i,
  input  logic [LVL_W-1:0]    rfr_thr_i,
  input  logic                en_we_i,
  input  logic [NUM_SRC-1:0]  en_wdata_i,
  input  logic                clr_we_i,
  input  logic [NUM_SRC-1:0]  clr_wdata_i,
  output logic [NUM_SRC-1:0]  status_o,
  output logic                irq_o,
  output logic                rx_rfr_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  evt_vec_t rise;
  logic     tx_hit, rx_hit;
  src_vec_t set_vec, clr_vec, sts, en_q, en_d;

  sei_edge_cap #(.N(NUM_EDGE)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .evt_i  (evt_i),
    .rise_o (rise)
  );

  sei_wm_cmp #(.LVL_W(LVL_W)) u_wm (
    .tx_fill_i (tx_fill_i),
    .rx_fill_i (rx_fill_i),
    .tx_thr_i  (tx_thr_i),
    .rx_thr_i  (rx_thr_i),
    .rfr_thr_i (rfr_thr_i),
    .tx_hit_o  (tx_hit),
    .rx_hit_o  (rx_hit),
    .rfr_o     (rx_rfr_o)
  );

  always_comb begin
    set_vec = {rx_hit, tx_hit, rise};
    clr_vec = clr_we_i ? clr_wdata_i : '0;
    en_d    = en_we_i ? en_wdata_i : en_q;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    sei_stat_bit #(.LEVEL(i >= NUM_EDGE)) u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_n_s),
      .set_i  (set_vec[i]),
      .clr_i  (clr_vec[i]),
      .sts_o  (sts[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s)     en_q <= '0;
    else if (en_we_i) en_q <= en_d;
  end

  always_comb begin
    status_o = sts;
    irq_o    = |(sts & en_q);
  end

  // R8: writing an all-zero enable silences the line
  a_r8_mask_all: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (en_we_i && en_wdata_i == '0) |=> !irq_o);
endmodule

// File: tb/sim_sei_irq_top.sv
module sim_sei_irq_top;
  import sei_irq_pkg::*;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic [NUM_EDGE-1:0] evt;
  logic [LW-1:0] txf, rxf, txt, rxt, rft;
  logic en_we, clr_we;
  logic [NUM_SRC-1:0] en_wd, clr_wd, status;
  logic irq, rfr;

  int n_cmp = 0;
  int n_bad = 0;
  logic [NUM_SRC-1:0]  m_sts, m_en;
  logic [NUM_EDGE-1:0] m_prev;
  logic                m_rfr;

  always #2.5 clk = ~clk;

  sei_irq_top #(.FIFO_DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .tx_fill_i(txf), .rx_fill_i(rxf),
    .tx_thr_i(txt), .rx_thr_i(rxt), .rfr_thr_i(rft), .en_we_i(en_we),
    .en_wdata_i(en_wd), .clr_we_i(clr_we), .clr_wdata_i(clr_wd),
    .status_o(status), .irq_o(irq), .rx_rfr_o(rfr)
  );

  function automatic logic [NUM_SRC-1:0] next_sts(input logic [NUM_SRC-1:0] s);
    logic [NUM_SRC-1:0] c, r;
    logic tc, rc;
    c  = clr_we ? clr_wd : '0;
    tc = (txt != 0) && (txf <= txt);
    rc = (rxt != 0) && (rxf >= rxt);
    r[NUM_EDGE-1:0] = (evt & ~m_prev) | (s[NUM_EDGE-1:0] & ~c[NUM_EDGE-1:0]);
    r[BIT_TXWM] = c[BIT_TXWM] ? 1'b0 : (s[BIT_TXWM] | tc);
    r[BIT_RXWM] = c[BIT_RXWM] ? 1'b0 : (s[BIT_RXWM] | rc);
    return r;
  endfunction

  task automatic tick(input string tag);
    m_sts  = next_sts(m_sts);
    m_prev = evt;
    if (en_we) m_en = en_wd;
    m_rfr  = (rxf < rft);
    @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (status !== m_sts) begin
      n_bad++;
      $display("FAIL %s status act=%h exp=%h", tag, status, m_sts);
    end
    n_cmp++;
    if (irq !== |(m_sts & m_en)) begin
      n_bad++;
      $display("FAIL %s (R8) irq act=%b exp=%b", tag, irq, |(m_sts & m_en));
    end
    n_cmp++;
    if (rfr !== m_rfr) begin
      n_bad++;
      $display("FAIL %s (R9) rx_rfr act=%b exp=%b", tag, rfr, m_rfr);
    end
  endtask

  task automatic idle();
    en_we = 0; clr_we = 0; en_wd = '0; clr_wd = '0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5E1_0042));
    rst_n = 0; evt = '0; txf = 0; rxf = 0; txt = 0; rxt = 0; rft = 0;
    idle();
    m_sts = '0; m_en = '0; m_prev = '0; m_rfr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, including the internal release cycles
    repeat (4) tick("R1");

    // R2: held input sets once; cleared, it stays clear
    evt[0] = 1; tick("R2");
    clr_we = 1; clr_wd = 13'h0001; tick("R2");
    idle(); tick("R2"); tick("R2");
    evt[0] = 0; tick("R2");

    // R3: a clear with a zero bit leaves the sticky bit alone
    evt[1] = 1; tick("R3"); evt[1] = 0;
    clr_we = 1; clr_wd = 13'h0004; tick("R3");
    idle(); tick("R3");

    // R4: rise and clear together, the set wins
    evt[3] = 1; clr_we = 1; clr_wd = 13'h0008; tick("R4");
    idle(); evt[3] = 0; tick("R4");

    // R10: separate error bits
    evt = 11'b101_0101_0000; tick("R10");
    evt = 11'b010_1010_0000; tick("R10");
    evt = '0; clr_we = 1; clr_wd = '1; tick("R10");
    idle(); tick("R10");

    // R5: zero threshold disables, boundary equality sets
    txt = 0; txf = 0; tick("R5"); tick("R5");
    txt = 4; txf = 5; tick("R5");
    txf = 4; tick("R5");

    // R7: clear while condition holds dips one cycle
    clr_we = 1; clr_wd = 13'h0800; tick("R7");
    idle(); tick("R7");
    txf = 9; clr_we = 1; clr_wd = 13'h0800; tick("R7");
    idle(); tick("R7");

    // R6: receive watermark at threshold and below
    rxt = 0; rxf = 16; tick("R6");
    rxt = 13; rxf = 12; tick("R6");
    rxf = 13; tick("R6");
    clr_we = 1; clr_wd = 13'h1000; rxf = 2; tick("R6");
    idle(); tick("R6");

    // R8: enable gating
    evt[2] = 1; tick("R8"); evt[2] = 0;
    en_we = 1; en_wd = 13'h0004; tick("R8");
    idle(); tick("R8");
    en_we = 1; en_wd = '0; tick("R8");
    idle(); tick("R8");

    // R9: ready-for-request boundary
    rft = 14; rxf = 13; tick("R9");
    rxf = 14; tick("R9");

    // mixed random traffic over R2..R10
    for (int k = 0; k < 3000; k++) begin
      evt = NUM_EDGE'($urandom) & NUM_EDGE'($urandom) & NUM_EDGE'($urandom);
      txf = LW'($urandom_range(0, DEPTH));
      rxf = LW'($urandom_range(0, DEPTH));
      if ($urandom_range(0, 15) == 0) txt = LW'($urandom_range(0, DEPTH));
      if ($urandom_range(0, 15) == 0) rxt = LW'($urandom_range(0, DEPTH));
      if ($urandom_range(0, 15) == 0) rft = LW'($urandom_range(0, DEPTH));
      clr_we = ($urandom_range(0, 3) == 0);
      clr_wd = NUM_SRC'($urandom);
      en_we  = ($urandom_range(0, 7) == 0);
      en_wd  = NUM_SRC'($urandom);
      tick("R3/R7 random");
    end
    idle();
    tick("R3/R7 random");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule